// File: doc/BRIEF.md
# Runahead Store Cache with Per-Word Poison Tracking

This block is a small, direct-mapped side cache that is active only while the core runs ahead past a long-latency miss. It accepts stores whose data or address carries a poison (INV) mark and keeps them apart from the real L1. Poisoned results therefore stay visible to later runahead loads, and the L1 never has to hold a mix of good and bad words in one line. Each word of each line carries its own poison flag.

For every load that the load-store queue could not satisfy by forwarding, the block looks up its own array in the same cycle that the L1 result arrives. If its own array hits, that result wins over the L1. If it misses, the L1 value passes through unchanged. If the L1 also missed, a request goes to the L2, where it acts as a prefetch.

A three-state controller sets when the side cache is live:
- `RAC_IDLE` is normal execution. The cache is bypassed.
- `RAC_RUN` is runahead mode. Stores are captured and loads are arbitrated.
- `RAC_PURGE` is a single exit cycle. The cache is bypassed, and all line valid, word-present and poison bits are wiped at its end.

The transitions are:
- ENTER: `RAC_IDLE` to `RAC_RUN` when `ra_mode` is high.
- EXIT: `RAC_RUN` to `RAC_PURGE` when `ra_mode` is low.
- DONE: `RAC_PURGE` to `RAC_IDLE`, always, after one cycle.

Top module: `runahead_cache`

## Requirements
- R1: After reset the controller is in `RAC_IDLE`. Every unforwarded load is served from the L1 (`ld_from_rc`=0, `ld_resp_inv`=0, `ld_resp_data`=`l1_data`).
- R2: The side cache is live only in `RAC_RUN`. It is entered one cycle after `ra_mode` is seen high in `RAC_IDLE`, and it is left through exactly one `RAC_PURGE` cycle after `ra_mode` is seen low. Outside `RAC_RUN`, stores are ignored and loads never hit the side cache.
- R3: In `RAC_RUN`, a store with `st_data_inv`=1 writes its word into the side cache and sets that word's poison flag. A later load of that word returns `ld_resp_inv`=1.
- R4: In `RAC_RUN`, a store with `st_addr_inv`=1 and clean data is treated as if its address were correct. It writes the side cache, and the word's poison flag is cleared.
- R5: In `RAC_RUN`, a clean store (both flags 0) updates a word only if that word is already present, and it clears that word's poison flag. A clean store to an absent word leaves the side cache unchanged.
- R6: Poison and presence are tracked per word. Writing one word leaves the data, poison flag and presence of the other words in the line unchanged.
- R7: A load with `ld_fwd_hit`=1 produces no response (`ld_resp_valid`=0) and no L2 request.
- R8: When the side cache hits, its data and poison flag are returned with `ld_from_rc`=1, even when `l1_hit`=1.
- R9: When the side cache misses, `l1_data` is returned with poison 0. If `l1_hit`=0 as well, `l2_req_valid`=1 and `l2_req_addr` equals `ld_addr` in the same cycle.
- R10: Addresses are word addresses laid out as follows:
  - bits [1:0] select the word in the line;
  - bits [3:2] select the line;
  - bits [11:4] form the tag.

  A poisoned store to a line that holds a different tag replaces that line, and the old words stop hitting.
- R11: After the `RAC_PURGE` cycle, every line is invalid. No load hits the side cache after re-entry until it is written again.
- R12: A load and a store to the same word in the same cycle return the contents as they were before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_mode | input | 1 | High while the core is in runahead mode |
| st_valid | input | 1 | Store request present |
| st_addr | input | 12 | Store word address |
| st_data | input | 16 | Store data |
| st_addr_inv | input | 1 | Store address is poisoned |
| st_data_inv | input | 1 | Store data is poisoned |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 12 | Load word address |
| ld_fwd_hit | input | 1 | Load was satisfied by load-store queue forwarding |
| l1_hit | input | 1 | L1 lookup hit for this load |
| l1_data | input | 16 | L1 data for this load |
| ld_resp_valid | output | 1 | Load response present |
| ld_resp_data | output | 16 | Returned load data |
| ld_resp_inv | output | 1 | Returned data is poisoned |
| ld_from_rc | output | 1 | Response came from the side cache |
| l2_req_valid | output | 1 | Prefetch request to L2 |
| l2_req_addr | output | 12 | Address of the L2 request |

## Verification
A store and a load can reach the same word in the same cycle. The load must see the array as it was before the edge that commits the store. The bench provokes this on purpose: it issues a poisoned store to a word that already holds clean data, with a load of that word in the same cycle. It also lets a random phase produce such pairs, with addresses drawn from a small pool of tags, lines and words. A behavioural reference model keyed by address is compared on every cycle before it applies that cycle's store. A design that forwards the incoming store would show a poisoned value one cycle early and be reported.

// File: rtl/rac_pkg.sv
package rac_pkg;
    typedef enum logic [1:0] {
        RAC_IDLE  = 2'd0,
        RAC_RUN   = 2'd1,
        RAC_PURGE = 2'd2
    } rac_state_e;
endpackage

// File: rtl/rac_ctrl.sv
module rac_ctrl
    import rac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ra_mode,
    output rac_state_e state,
    output logic       cache_on,
    output logic       purge
);
    rac_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RAC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RAC_IDLE:  if (ra_mode)  state_d = RAC_RUN;
            RAC_RUN:   if (!ra_mode) state_d = RAC_PURGE;
            RAC_PURGE: state_d = RAC_IDLE;
            default:   state_d = RAC_IDLE;
        endcase
    end

    always_comb begin
        cache_on = 1'b0;
        purge    = 1'b0;
        unique case (state_q)
            RAC_IDLE:  ;
            RAC_RUN:   cache_on = 1'b1;
            RAC_PURGE: purge    = 1'b1;
            default:   ;
        endcase
    end

    assign state = state_q;

    // R2
    purge_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == RAC_PURGE |=> state_q == RAC_IDLE);

    // R2
    exit_to_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RAC_RUN && !ra_mode) |=> state_q == RAC_PURGE);
endmodule

// File: rtl/rac_array.sv
module rac_array #(
    parameter int AW    = 12,
    parameter int DW    = 16,
    parameter int LINES = 4,
    parameter int WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_inv,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data,
    output logic          rd_inv,
    output logic          wr_present
);
    localparam int OB = $clog2(WORDS);
    localparam int IB = $clog2(LINES);
    localparam int TB = AW - IB - OB;

    logic [LINES-1:0] valid_q;
    logic [TB-1:0]    tag_q   [LINES];
    logic [WORDS-1:0] wmask_q [LINES];
    logic [WORDS-1:0] inv_q   [LINES];
    logic [DW-1:0]    data_q  [LINES][WORDS];

    logic [IB-1:0]    w_idx, r_idx;
    logic [OB-1:0]    w_off, r_off;
    logic [TB-1:0]    w_tag, r_tag;
    logic [WORDS-1:0] w_onehot;
    logic             w_line_match;

    assign w_off = wr_addr[OB-1:0];
    assign w_idx = wr_addr[OB +: IB];
    assign w_tag = wr_addr[AW-1 -: TB];
    assign r_off = rd_addr[OB-1:0];
    assign r_idx = rd_addr[OB +: IB];
    assign r_tag = rd_addr[AW-1 -: TB];

    always_comb begin
        w_onehot        = '0;
        w_onehot[w_off] = 1'b1;
    end

    assign w_line_match = valid_q[w_idx] && (tag_q[w_idx] == w_tag);
    assign wr_present   = w_line_match && wmask_q[w_idx][w_off];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                wmask_q[i] <= '0;
                inv_q[i]   <= '0;
                tag_q[i]   <= '0;
            end
        end else if (wr_en) begin
            valid_q[w_idx] <= 1'b1;
            tag_q[w_idx]   <= w_tag;
            if (w_line_match) begin
                wmask_q[w_idx][w_off] <= 1'b1;
                inv_q[w_idx][w_off]   <= wr_inv;
            end else begin
                wmask_q[w_idx] <= w_onehot;
                inv_q[w_idx]   <= wr_inv ? w_onehot : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) data_q[w_idx][w_off] <= wr_data;
    end

    assign rd_hit  = valid_q[r_idx] && (tag_q[r_idx] == r_tag) && wmask_q[r_idx][r_off];
    assign rd_data = data_q[r_idx][r_off];
    assign rd_inv  = inv_q[r_idx][r_off];

    // R11
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> valid_q == '0);

    // R3
    poison_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_inv && !clear) |=> inv_q[$past(w_idx)][$past(w_off)]);

    // R10
    line_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> valid_q[$past(w_idx)] && tag_q[$past(w_idx)] == $past(w_tag));
endmodule

// File: rtl/rac_load_sel.sv
module rac_load_sel #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          cache_on,
    input  logic          ld_valid,
    input  logic          ld_fwd_hit,
    input  logic [AW-1:0] ld_addr,
    input  logic          rc_hit,
    input  logic [DW-1:0] rc_data,
    input  logic          rc_inv,
    input  logic          l1_hit,
    input  logic [DW-1:0] l1_data,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data,
    output logic          resp_inv,
    output logic          resp_from_rc,
    output logic          l2_req,
    output logic [AW-1:0] l2_addr
);
    logic use_rc;

    always_comb begin
        resp_valid   = ld_valid && !ld_fwd_hit;
        use_rc       = resp_valid && cache_on && rc_hit;
        resp_from_rc = use_rc;
        resp_data    = '0;
        resp_inv     = 1'b0;
        l2_req       = 1'b0;
        l2_addr      = '0;
        if (use_rc) begin
            resp_data = rc_data;
            resp_inv  = rc_inv;
        end else if (resp_valid) begin
            resp_data = l1_data;
            if (!l1_hit) begin
                l2_req  = 1'b1;
                l2_addr = ld_addr;
            end
        end
    end
endmodule

// File: rtl/runahead_cache.sv
module runahead_cache
    import rac_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 16,
    parameter int LINES = 4,
    parameter int WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ra_mode,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          st_addr_inv,
    input  logic          st_data_inv,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_fwd_hit,
    input  logic          l1_hit,
    input  logic [DW-1:0] l1_data,
    output logic          ld_resp_valid,
    output logic [DW-1:0] ld_resp_data,
    output logic          ld_resp_inv,
    output logic          ld_from_rc,
    output logic          l2_req_valid,
    output logic [AW-1:0] l2_req_addr
);
    rac_state_e    state;
    logic          cache_on, purge;
    logic          st_we, wr_present;
    logic          rc_hit, rc_inv;
    logic [DW-1:0] rc_data;

    rac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_mode  (ra_mode),
        .state    (state),
        .cache_on (cache_on),
        .purge    (purge)
    );

    assign st_we = cache_on && st_valid && (st_addr_inv || st_data_inv || wr_present);

    rac_array #(.AW(AW), .DW(DW), .LINES(LINES), .WORDS(WORDS)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (purge),
        .wr_en      (st_we),
        .wr_addr    (st_addr),
        .wr_data    (st_data),
        .wr_inv     (st_data_inv),
        .rd_addr    (ld_addr),
        .rd_hit     (rc_hit),
        .rd_data    (rc_data),
        .rd_inv     (rc_inv),
        .wr_present (wr_present)
    );

    rac_load_sel #(.AW(AW), .DW(DW)) u_sel (
        .cache_on     (cache_on),
        .ld_valid     (ld_valid),
        .ld_fwd_hit   (ld_fwd_hit),
        .ld_addr      (ld_addr),
        .rc_hit       (rc_hit),
        .rc_data      (rc_data),
        .rc_inv       (rc_inv),
        .l1_hit       (l1_hit),
        .l1_data      (l1_data),
        .resp_valid   (ld_resp_valid),
        .resp_data    (ld_resp_data),
        .resp_inv     (ld_resp_inv),
        .resp_from_rc (ld_from_rc),
        .l2_req       (l2_req_valid),
        .l2_addr      (l2_req_addr)
    );

    // R7
    fwd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_fwd_hit) |-> (!ld_resp_valid && !l2_req_valid));

    // R2
    rc_only_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_from_rc |-> state == RAC_RUN);

    // R9
    l2_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |-> (l2_req_addr == ld_addr && !ld_from_rc && !l1_hit));

    // R8
    rc_no_prefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_from_rc |-> !l2_req_valid);
endmodule

// File: tb/sim_runahead_cache.sv
`timescale 1ns/1ps
module sim_runahead_cache;
    localparam int AW = 12, DW = 16, LINES = 4, WORDS = 4;
    localparam int OB = 2, IB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ra_mode = 1'b0;
    logic          st_valid = 1'b0, st_addr_inv = 1'b0, st_data_inv = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          ld_valid = 1'b0, ld_fwd_hit = 1'b0, l1_hit = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] l1_data = '0;
    logic          ld_resp_valid, ld_resp_inv, ld_from_rc, l2_req_valid;
    logic [DW-1:0] ld_resp_data;
    logic [AW-1:0] l2_req_addr;

    always #4 clk = ~clk;

    runahead_cache #(.AW(AW), .DW(DW), .LINES(LINES), .WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .ra_mode(ra_mode),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_addr_inv(st_addr_inv), .st_data_inv(st_data_inv),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_fwd_hit(ld_fwd_hit),
        .l1_hit(l1_hit), .l1_data(l1_data),
        .ld_resp_valid(ld_resp_valid), .ld_resp_data(ld_resp_data),
        .ld_resp_inv(ld_resp_inv), .ld_from_rc(ld_from_rc),
        .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr)
    );

    int vectors = 0;
    int miscompares = 0;
    int mst = 0;
    logic [DW:0] model [int];

    function automatic int idx_of(int k); return (k >> OB) & (LINES - 1); endfunction
    function automatic int tag_of(int k); return k >> (OB + IB); endfunction
    function automatic logic [AW-1:0] mk(int t, int i, int w);
        return AW'((t << (OB + IB)) | (i << OB) | w);
    endfunction

    task automatic quiet();
        st_valid = 0; st_addr_inv = 0; st_data_inv = 0;
        ld_valid = 0; ld_fwd_hit = 0; l1_hit = 0; l1_data = '0;
    endtask

    task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d, logic ai, logic di);
        st_valid = 1; st_addr = a; st_data = d; st_addr_inv = ai; st_data_inv = di;
    endtask

    task automatic do_load(logic [AW-1:0] a, logic hit, logic [DW-1:0] d, logic fwd);
        ld_valid = 1; ld_addr = a; l1_hit = hit; l1_data = d; ld_fwd_hit = fwd;
    endtask

    task automatic check(string req);
        int k;
        logic e_resp, e_rc, e_inv, e_l2, bad;
        logic [DW-1:0] e_data;
        k = int'(ld_addr);
        e_resp = ld_valid && !ld_fwd_hit;
        e_rc   = e_resp && mst == 1 && model.exists(k);
        e_data = !e_resp ? '0 : (e_rc ? model[k][DW-1:0] : l1_data);
        e_inv  = e_rc && model[k][DW];
        e_l2   = e_resp && !e_rc && !l1_hit;
        bad = (ld_resp_valid !== e_resp) || (ld_resp_data !== e_data) ||
              (ld_resp_inv !== e_inv) || (ld_from_rc !== e_rc) ||
              (l2_req_valid !== e_l2) || (e_l2 && l2_req_addr !== ld_addr);
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL %s: got resp=%b data=%h inv=%b rc=%b l2=%b/%h expected resp=%b data=%h inv=%b rc=%b l2=%b/%h",
                     req, ld_resp_valid, ld_resp_data, ld_resp_inv, ld_from_rc, l2_req_valid,
                     l2_req_addr, e_resp, e_data, e_inv, e_rc, e_l2, ld_addr);
        end
    endtask

    task automatic model_step();
        int k;
        int drop[$];
        if (mst == 1 && st_valid) begin
            k = int'(st_addr);
            if (st_addr_inv || st_data_inv || model.exists(k)) begin
                foreach (model[j])
                    if (idx_of(j) == idx_of(k) && tag_of(j) != tag_of(k)) drop.push_back(j);
                foreach (drop[n]) model.delete(drop[n]);
                model[k] = {st_data_inv, st_data};
            end
        end
        case (mst)
            0: if (ra_mode) mst = 1;
            1: if (!ra_mode) mst = 2;
            default: begin model.delete(); mst = 0; end
        endcase
    endtask

    task automatic cyc(string req);
        @(negedge clk);
        check(req);
        @(posedge clk);
        model_step();
        #1;
        quiet();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected finish before timeout");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [AW-1:0] a, a1, b, ac;
        a  = mk(5, 1, 2);
        a1 = mk(5, 1, 3);
        b  = mk(5, 2, 0);
        ac = mk(9, 1, 2);
        quiet();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state, loads served by L1
        do_load(a, 1, 16'h1111, 0); cyc("R1");
        do_load(b, 0, 16'h2222, 0); cyc("R1");
        // R2: store while idle is ignored
        do_store(a, 16'hDEAD, 0, 1); do_load(a, 1, 16'h3333, 0); cyc("R2");
        ra_mode = 1;
        do_store(a, 16'hDEAD, 0, 1); cyc("R2");   // still idle this cycle
        do_load(a, 1, 16'h4444, 0); cyc("R2");   // now running, cache empty
        // R3: poisoned data store
        do_store(a, 16'hBEEF, 0, 1); cyc("R3");
        do_load(a, 1, 16'h5555, 0); cyc("R8");   // rc wins over L1 hit
        // R6: neighbour word untouched
        do_load(a1, 1, 16'h6666, 0); cyc("R6");
        // R4: poisoned address, clean data
        do_store(a1, 16'hA1A1, 1, 0); cyc("R4");
        do_load(a1, 0, 16'h7777, 0); cyc("R4");
        do_load(a, 0, 16'h7777, 0); cyc("R6");
        // R5: clean store to present word clears poison
        do_store(a, 16'hC0DE, 0, 0); cyc("R5");
        do_load(a, 1, 16'h8888, 0); cyc("R5");
        // R5: clean store to absent word ignored
        do_store(b, 16'hFACE, 0, 0); cyc("R5");
        do_load(b, 1, 16'h9999, 0); cyc("R5");
        // R7: forwarded load silent
        do_load(a, 0, 16'h1234, 1); cyc("R7");
        // R9: side miss and L1 miss
        do_load(mk(3, 3, 1), 0, 16'h4321, 0); cyc("R9");
        do_load(mk(3, 3, 1), 1, 16'h4321, 0); cyc("R9");
        // R10: conflicting tag replaces the line
        do_store(ac, 16'h0BAD, 0, 1); cyc("R10");
        do_load(a, 0, 16'hABCD, 0); cyc("R10");
        do_load(a1, 1, 16'hABCE, 0); cyc("R10");
        do_load(ac, 1, 16'hABCF, 0); cyc("R10");
        // R12: same-cycle store and load to one word
        do_store(ac, 16'h0123, 0, 0); cyc("R12");
        do_store(ac, 16'h0F0F, 0, 1); do_load(ac, 1, 16'hEEEE, 0); cyc("R12");
        do_load(ac, 1, 16'hEEEE, 0); cyc("R12");
        // R2/R11: exit, purge, re-entry
        ra_mode = 0;
        do_store(b, 16'h5A5A, 0, 1); do_load(ac, 1, 16'h1010, 0); cyc("R2");
        do_load(ac, 1, 16'h2020, 0); cyc("R2");  // purge cycle bypass
        do_store(b, 16'h5A5A, 0, 1); do_load(b, 1, 16'h3030, 0); cyc("R2");
        ra_mode = 1;
        do_load(ac, 0, 16'h4040, 0); cyc("R11");
        do_load(ac, 0, 16'h5050, 0); cyc("R11");
        do_load(b, 1, 16'h6060, 0); cyc("R11");

        // R8, R12 and others under mixed random traffic
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 39) == 0) ra_mode = ~ra_mode;
            if ($urandom_range(0, 1) == 1)
                do_store(mk($urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 3)),
                         DW'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) != 0)
                do_load(mk($urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 3)),
                        1'($urandom_range(0, 1)), DW'($urandom), 1'($urandom_range(0, 5) == 0));
            cyc("R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule